// File: doc/BRIEF.md
# Branch-Link Invalidation Tracker

This block keeps the valid bits of the branch links in a way-memoizing instruction cache coherent with line replacement. A branch link sits at a location given by the source line and a slot within it, and it names a target line. When a target line is evicted, every link that points into it must stop being valid. The tracker records, for each target line, the location of the first link created into it. When a second, different link arrives, it sets an overflow flag on that line instead.

On eviction, a line with only its recorded link gets a precise single-link clear. A line that overflowed forces a flash clear of every branch-link valid bit and every pointer. A line with neither causes no clear. The fetch unit reads the valid bits from the `linkValid` output. The surrounding cache control observes the clear pulses.

Two cheaper variants are chosen by the `MODE` parameter. In the zero-link mode no pointer is kept and every link sets overflow on its target. In the oblivious mode no tracking is kept at all and every eviction flash-clears.

Top module: `brlink_tracker`

## Requirements
- R1: After reset every branch-link valid bit is 0 and both `clrOne` and `clrAll` are 0.
- R2: A link creation with source location `linkSrc` sets `linkValid[linkSrc]` at the next clock edge. The location encoding is line*LINK_SLOTS + slot.
- R3: In mode 0 (one-link), evicting a line whose pointer holds location L and whose overflow flag is clear pulses `clrOne` with `clrOneLoc` = L on the following cycle. That cycle only `linkValid[L]` is cleared.
- R4: In mode 0, creating a link into a line whose pointer already holds a different location sets that line's overflow flag. Evicting the line then pulses `clrAll`, clears every valid bit, and drops every pointer in the structure.
- R5: Creating a link whose source equals the target line's recorded pointer does not set overflow.
- R6: Evicting a line with no pointer and no overflow issues no clear and leaves all valid bits unchanged.
- R7: An eviction clears the victim line's own pointer and overflow flag.
- R8: A single-link clear of location L also drops the pointer of every other line that still records L.
- R9: When a link creation and an eviction arrive in the same cycle, the eviction is applied first and the link creation is applied to the resulting state.
- R10: `clrOne` and `clrAll` are never 1 in the same cycle, and each lasts one cycle per eviction.
- R11: In mode 1 (zero-link), every link creation sets overflow on its target, so evicting any linked line pulses `clrAll`. Evicting an unlinked line pulses nothing.
- R12: In mode 2 (oblivious), every eviction pulses `clrAll` and clears all valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| linkReq | input | 1 | Create a branch link this cycle |
| linkSrc | input | LOC_W | Location of the link being created |
| linkTgt | input | LINE_W | Line the new link points into |
| evictReq | input | 1 | Evict a line this cycle |
| evictLine | input | LINE_W | Line being evicted |
| clrOne | output | 1 | Single-link clear pulse |
| clrOneLoc | output | LOC_W | Location cleared by `clrOne` |
| clrAll | output | 1 | Global flash-clear pulse |
| linkValid | output | NUM_LOCS | Branch-link valid bits |

## Verification
The bench targets these corner cases:
- A source slot re-linked to a new line. If stale pointers survived a precise clear, a later link would find the pointer occupied and escalate to a needless flash clear.
- Re-creating an identical link. A design that counts it as a second link would flash-clear where one precise clear suffices.
- A link and an eviction of the same line in one cycle. Applying them in the wrong order would either lose the fresh link's valid bit or leave it untracked, so a later eviction misses it.
- Back-to-back evictions of one line. These show whether the victim's pointer and overflow flag are retired.
- The two reduced modes, checked on their own instances for the clear they must and must not raise.

// File: rtl/brlink_pkg.sv
package brlink_pkg;

  localparam int MODE_ONE_LINK  = 0;
  localparam int MODE_ZERO_LINK = 1;
  localparam int MODE_OBLIVIOUS = 2;

  typedef struct packed {
    logic doClrAll;
    logic doClrOne;
    logic doEvict;
    logic doLink;
  } strobe_t;

endpackage

// File: rtl/brlink_ctrl.sv
module brlink_ctrl
  import brlink_pkg::*;
#(
  parameter int LOC_W = 6,
  parameter int MODE  = MODE_ONE_LINK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             linkReq,
  input  logic             evictReq,
  input  logic             victimPtrValid,
  input  logic             victimOvf,
  input  logic [LOC_W-1:0] victimPtr,
  output strobe_t          stb,
  output logic             clrAllQ,
  output logic             clrOneQ,
  output logic [LOC_W-1:0] clrLocQ
);

  logic wantAll;
  logic wantOne;

  generate
    if (MODE == MODE_OBLIVIOUS) begin : g_obliv
      assign wantAll = evictReq;
      assign wantOne = 1'b0;
    end else if (MODE == MODE_ZERO_LINK) begin : g_zero
      assign wantAll = evictReq && victimOvf;
      assign wantOne = 1'b0;
    end else begin : g_one
      assign wantAll = evictReq && victimOvf;
      assign wantOne = evictReq && !victimOvf && victimPtrValid;
    end
  endgenerate

  always_comb begin
    stb.doClrAll = wantAll;
    stb.doClrOne = wantOne;
    stb.doEvict  = evictReq;
    stb.doLink   = linkReq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clrAllQ <= 1'b0;
      clrOneQ <= 1'b0;
      clrLocQ <= '0;
    end else begin
      clrAllQ <= wantAll;
      clrOneQ <= wantOne;
      clrLocQ <= wantOne ? victimPtr : '0;
    end
  end

  // R10: the two clear commands are mutually exclusive
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(clrAllQ && clrOneQ));

  // R10: no clear without an eviction in the previous cycle
  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evictReq |=> !clrAllQ && !clrOneQ);

  generate
    if (MODE == MODE_OBLIVIOUS) begin : g_chk_obliv
      assert_obliv_all_R12: assert property (@(posedge clk) disable iff (!rst_n)
        evictReq |=> clrAllQ);
    end else begin : g_chk_track
      assert_overflow_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evictReq && victimOvf |=> clrAllQ);
    end
  endgenerate

endmodule

// File: rtl/brlink_datapath.sv
module brlink_datapath
  import brlink_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_LOCS  = 64,
  parameter int LINE_W    = 4,
  parameter int LOC_W     = 6,
  parameter int MODE      = MODE_ONE_LINK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [LOC_W-1:0]    linkSrc,
  input  logic [LINE_W-1:0]   linkTgt,
  input  logic [LINE_W-1:0]   evictLine,
  output logic                victimPtrValid,
  output logic                victimOvf,
  output logic [LOC_W-1:0]    victimPtr,
  output logic [NUM_LOCS-1:0] validVec
);

  logic [LOC_W-1:0]    ptrQ   [NUM_LINES];
  logic [LOC_W-1:0]    ptrN   [NUM_LINES];
  logic [NUM_LINES-1:0] ptrVQ, ptrVN;
  logic [NUM_LINES-1:0] ovfQ,  ovfN;
  logic [NUM_LOCS-1:0]  validQ, validN;

  assign victimPtrValid = ptrVQ[evictLine];
  assign victimOvf      = ovfQ[evictLine];
  assign victimPtr      = ptrQ[evictLine];
  assign validVec       = validQ;

  always_comb begin
    validN = validQ;
    ptrVN  = ptrVQ;
    ovfN   = ovfQ;
    for (int i = 0; i < NUM_LINES; i++) ptrN[i] = ptrQ[i];

    // eviction side first
    if (stb.doClrAll) begin
      validN = '0;
      ptrVN  = '0;
      ovfN   = '0;
    end
    if (stb.doClrOne) begin
      validN[victimPtr] = 1'b0;
      for (int i = 0; i < NUM_LINES; i++)
        if (ptrVQ[i] && ptrQ[i] == victimPtr) ptrVN[i] = 1'b0;
    end
    if (stb.doEvict) begin
      ptrVN[evictLine] = 1'b0;
      ovfN[evictLine]  = 1'b0;
    end

    // then link creation on the updated state
    if (stb.doLink) begin
      validN[linkSrc] = 1'b1;
      if (MODE == MODE_ONE_LINK) begin
        if (!ptrVN[linkTgt]) begin
          ptrVN[linkTgt] = 1'b1;
          ptrN[linkTgt]  = linkSrc;
        end else if (ptrN[linkTgt] != linkSrc) begin
          ovfN[linkTgt] = 1'b1;
        end
      end else if (MODE == MODE_ZERO_LINK) begin
        ovfN[linkTgt] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      ptrVQ  <= '0;
      ovfQ   <= '0;
      for (int i = 0; i < NUM_LINES; i++) ptrQ[i] <= '0;
    end else begin
      validQ <= validN;
      ptrVQ  <= ptrVN;
      ovfQ   <= ovfN;
      for (int i = 0; i < NUM_LINES; i++) ptrQ[i] <= ptrN[i];
    end
  end

  // R2: a created link is valid on the next cycle
  assert_link_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doLink |=> validQ[$past(linkSrc)]);

  // R7: victim pointer and overflow retired unless relinked in the same cycle
  assert_victim_retired_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doEvict && !(stb.doLink && linkTgt == evictLine)
      |=> !ptrVQ[$past(evictLine)] && !ovfQ[$past(evictLine)]);

  // R3: a precise clear drops its location unless that slot is relinked
  assert_single_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doClrOne && !(stb.doLink && linkSrc == victimPtr)
      |=> !validQ[$past(victimPtr)]);

  // R4: no pointer or overflow survives a flash clear unless just linked
  assert_flash_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doClrAll && !stb.doLink |=> ptrVQ == '0 && ovfQ == '0);

endmodule

// File: rtl/brlink_tracker.sv
module brlink_tracker
  import brlink_pkg::*;
#(
  parameter int NUM_LINES  = 16,
  parameter int LINK_SLOTS = 4,
  parameter int MODE       = MODE_ONE_LINK,
  localparam int NUM_LOCS  = NUM_LINES * LINK_SLOTS,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int LOC_W     = $clog2(NUM_LOCS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                linkReq,
  input  logic [LOC_W-1:0]    linkSrc,
  input  logic [LINE_W-1:0]   linkTgt,
  input  logic                evictReq,
  input  logic [LINE_W-1:0]   evictLine,
  output logic                clrOne,
  output logic [LOC_W-1:0]    clrOneLoc,
  output logic                clrAll,
  output logic [NUM_LOCS-1:0] linkValid
);

  strobe_t          stb;
  logic             victimPtrValid;
  logic             victimOvf;
  logic [LOC_W-1:0] victimPtr;

  brlink_ctrl #(.LOC_W(LOC_W), .MODE(MODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .linkReq(linkReq), .evictReq(evictReq),
    .victimPtrValid(victimPtrValid), .victimOvf(victimOvf), .victimPtr(victimPtr),
    .stb(stb), .clrAllQ(clrAll), .clrOneQ(clrOne), .clrLocQ(clrOneLoc)
  );

  brlink_datapath #(
    .NUM_LINES(NUM_LINES), .NUM_LOCS(NUM_LOCS),
    .LINE_W(LINE_W), .LOC_W(LOC_W), .MODE(MODE)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .linkSrc(linkSrc), .linkTgt(linkTgt), .evictLine(evictLine),
    .victimPtrValid(victimPtrValid), .victimOvf(victimOvf), .victimPtr(victimPtr),
    .validVec(linkValid)
  );

  // R4: after a flash clear at most the same-cycle link remains valid
  assert_flash_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clrAll |-> $countones(linkValid) <= 1);

endmodule

// File: tb/sim_brlink_tracker.sv
`timescale 1ns/1ps
module sim_brlink_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       linkReq = 1'b0;
  logic [5:0] linkSrc = '0;
  logic [3:0] linkTgt = '0;
  logic       evictReq = 1'b0;
  logic [3:0] evictLine = '0;

  logic        clrOne0, clrAll0, clrOne1, clrAll1, clrOne2, clrAll2;
  logic [5:0]  loc0, loc1, loc2;
  logic [63:0] val0, val1, val2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brlink_tracker u0 (.clk(clk), .rst_n(rst_n), .linkReq(linkReq), .linkSrc(linkSrc),
    .linkTgt(linkTgt), .evictReq(evictReq), .evictLine(evictLine),
    .clrOne(clrOne0), .clrOneLoc(loc0), .clrAll(clrAll0), .linkValid(val0));
  brlink_tracker #(.MODE(1)) u1 (.clk(clk), .rst_n(rst_n), .linkReq(linkReq), .linkSrc(linkSrc),
    .linkTgt(linkTgt), .evictReq(evictReq), .evictLine(evictLine),
    .clrOne(clrOne1), .clrOneLoc(loc1), .clrAll(clrAll1), .linkValid(val1));
  brlink_tracker #(.MODE(2)) u2 (.clk(clk), .rst_n(rst_n), .linkReq(linkReq), .linkSrc(linkSrc),
    .linkTgt(linkTgt), .evictReq(evictReq), .evictLine(evictLine),
    .clrOne(clrOne2), .clrOneLoc(loc2), .clrAll(clrAll2), .linkValid(val2));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
  endtask

  task automatic link(input int src, input int tgt);
    linkReq = 1'b1; linkSrc = src[5:0]; linkTgt = tgt[3:0];
    tick();
    linkReq = 1'b0;
  endtask

  task automatic evict(input int line);
    evictReq = 1'b1; evictLine = line[3:0];
    tick();
    evictReq = 1'b0;
    chk("R10 exclusive", {63'd0, clrAll0 & clrOne0}, 64'd0);
  endtask

  task automatic idle();
    tick();
  endtask

  task automatic testReset();
    doReset();
    chk("R1 valid", val0, 64'd0);
    chk("R1 clrAll", {63'd0, clrAll0}, 64'd0);
    chk("R1 clrOne", {63'd0, clrOne0}, 64'd0);
  endtask

  task automatic testFirstLink();
    doReset();
    link(5, 3);
    chk("R2 valid set", val0, 64'd1 << 5);
    link(9, 7);
    evict(3);
    chk("R3 clrOne", {63'd0, clrOne0}, 64'd1);
    chk("R3 loc", {58'd0, loc0}, 64'd5);
    chk("R3 clrAll", {63'd0, clrAll0}, 64'd0);
    chk("R3 valid", val0, 64'd1 << 9);
    idle();
    chk("R10 pulse", {63'd0, clrOne0}, 64'd0);
  endtask

  task automatic testOverflow();
    doReset();
    link(10, 2); link(20, 2); link(30, 4);
    evict(2);
    chk("R4 clrAll", {63'd0, clrAll0}, 64'd1);
    chk("R4 clrOne", {63'd0, clrOne0}, 64'd0);
    chk("R4 valid", val0, 64'd0);
    evict(4);
    chk("R4 ptr dropped", {62'd0, clrAll0, clrOne0}, 64'd0);
  endtask

  task automatic testSameLink();
    doReset();
    link(12, 6); link(12, 6);
    evict(6);
    chk("R5 clrAll", {63'd0, clrAll0}, 64'd0);
    chk("R5 clrOne", {63'd0, clrOne0}, 64'd1);
    chk("R5 loc", {58'd0, loc0}, 64'd12);
  endtask

  task automatic testNoPtr();
    doReset();
    link(40, 1);
    evict(8);
    chk("R6 no clear", {62'd0, clrAll0, clrOne0}, 64'd0);
    chk("R6 valid", val0, 64'd1 << 40);
  endtask

  task automatic testRetire();
    doReset();
    link(41, 9); link(42, 9);
    evict(9);
    chk("R7 first clrAll", {63'd0, clrAll0}, 64'd1);
    link(43, 9);
    evict(9);
    chk("R7 clrOne", {62'd0, clrAll0, clrOne0}, 64'd1);
    chk("R7 loc", {58'd0, loc0}, 64'd43);
    evict(9);
    chk("R7 no clear", {62'd0, clrAll0, clrOne0}, 64'd0);
  endtask

  task automatic testDrop();
    doReset();
    link(17, 10); link(17, 11);
    evict(10);
    chk("R8 clrOne", {62'd0, clrAll0, clrOne0}, 64'd1);
    chk("R8 loc", {58'd0, loc0}, 64'd17);
    chk("R8 valid", val0, 64'd0);
    link(18, 11);
    evict(11);
    chk("R8 precise", {62'd0, clrAll0, clrOne0}, 64'd1);
    chk("R8 loc2", {58'd0, loc0}, 64'd18);
  endtask

  task automatic testCollide();
    doReset();
    link(50, 12); link(51, 12);
    linkReq = 1'b1; linkSrc = 6'd52; linkTgt = 4'd12;
    evict(12);
    linkReq = 1'b0;
    chk("R9 clrAll", {63'd0, clrAll0}, 64'd1);
    chk("R9 valid", val0, 64'd1 << 52);
    evict(12);
    chk("R9 tracked", {62'd0, clrAll0, clrOne0}, 64'd1);
    chk("R9 loc", {58'd0, loc0}, 64'd52);
  endtask

  task automatic testZero();
    doReset();
    link(3, 5);
    evict(5);
    chk("R11 clrAll", {62'd0, clrAll1, clrOne1}, 64'd2);
    chk("R11 valid", val1, 64'd0);
    evict(6);
    chk("R11 unlinked", {62'd0, clrAll1, clrOne1}, 64'd0);
  endtask

  task automatic testOblivious();
    doReset();
    link(8, 1);
    evict(7);
    chk("R12 clrAll", {62'd0, clrAll2, clrOne2}, 64'd2);
    chk("R12 valid", val2, 64'd0);
  endtask

  initial begin
    testReset();
    testFirstLink();
    testOverflow();
    testSameLink();
    testNoPtr();
    testRetire();
    testDrop();
    testCollide();
    testZero();
    testOblivious();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule